// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers nine interrupt sources and hands them, one at a time, to a service sequencer. Four of them are contact inputs. Each contact input is synchronised and edge-detected according to its own two-bit mode. The other five arrive as one-cycle event strobes: an interval timer tick, two pulse-output target matches and two counter target matches. A match strobe is raised when a present value equals its preset target. Every source has a pending latch, and a per-source enable mask decides which pending requests take part in arbitration.

The four contact inputs form the upper priority level and the five event sources form the lower level. Within a level the lowest source index wins. A request may preempt a running service only if its level is strictly higher. An upper-level service that preempts a lower one pushes the interrupted service onto a two-entry stack. When the sequencer signals completion, the interrupted service resumes and a resume pulse reports its vector. Requests of the same or a lower level wait until the running service completes.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `disp_valid_o`, `resume_o` and `active_o` are low and `cur_vec_o` is 0.
- R2: Contact input i uses mode bits `edge_mode_i[2i+1:2i]`. Bit 0 requests on a rising edge and bit 1 requests on a falling edge, so 11 requests on both edges and 00 never requests.
- R3: The source vector numbering is: inputs 0..3 map to 0..3, timer to 4, pulse-output 1 to 5, pulse-output 2 to 6, counter 1 to 7 and counter 2 to 8. `ev_strobe_i` bits 0..4 carry sources 4..8. A strobe sampled at clock edge k, with the block idle and the source enabled, gives a one-cycle `disp_valid_o` after edge k+1.
- R4: Contact-input requests that are pending together are dispatched in ascending input index.
- R5: Event requests that are pending together are dispatched in the order timer, pulse-output 1, pulse-output 2, counter 1, counter 2.
- R6: When requests of both levels are pending at once, a contact input is dispatched first.
- R7: While only a lower-level service runs, a pending contact-input request is dispatched at once and preempts it.
- R8: A request of the same level as the running service, or of a lower level, is not dispatched until that service completes.
- R9: A completion pulse (`svc_done_i`) that ends a preempting service while a lower-level service is stacked produces one `resume_o` pulse. After it, `cur_vec_o` equals the stacked vector, and no new dispatch is produced in that cycle.
- R10: Repeated events on a source that is already pending merge into one dispatch. An event in the same cycle as that source's dispatch is kept as a new request.
- R11: A source whose enable bit is low is never dispatched, but its request stays latched and is dispatched once the bit is set.
- R12: A completion pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_IN | Raw contact inputs (asynchronous) |
| edge_mode_i | input | 2*NUM_IN | Per-input edge mode, two bits each |
| ev_strobe_i | input | NUM_EV | Event strobes: timer, pulse 1, pulse 2, counter 1, counter 2 |
| enable_i | input | NUM_IN+NUM_EV | Per-source arbitration enable |
| svc_done_i | input | 1 | Pulse: current service has returned |
| disp_valid_o | output | 1 | One-cycle dispatch strobe |
| disp_vec_o | output | VEC_W | Vector of the dispatched source |
| resume_o | output | 1 | One-cycle pulse: an interrupted service resumes |
| active_o | output | 1 | A service is running |
| cur_vec_o | output | VEC_W | Vector of the running service (0 when idle) |

## Verification
Two things can coincide in one cycle. The first is a source's dispatch with a fresh event on the same source. The bench provokes it by holding the timer strobe for two cycles, so the second sample lands on the dispatch edge. It then expects a second timer dispatch after completion instead of a merged single one. The second is a completion pulse while an upper-level request is already pending and a lower-level service is stacked. The bench expects completion to win: first the resume, then an immediate fresh preemption, with the dispatch order logged and compared.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // edge mode bit positions inside each two-bit field
  localparam int EM_RISE = 0;
  localparam int EM_FALL = 1;

  typedef logic [1:0] edge_mode_t;

  // lowest set index of a request vector, and whether one was found
  typedef struct packed {
    logic       found;
    logic [7:0] idx;
  } pick_t;
endpackage

// File: rtl/nic_edge_det.sv
module nic_edge_det
  import nic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  edge_mode_t mode_i,
  output logic       hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    cur   = sync_q[SYNC_STAGES-1];
    rise  = cur & ~prev_q;
    fall  = ~cur & prev_q;
    hit_o = (mode_i[EM_RISE] & rise) | (mode_i[EM_FALL] & fall);
  end

  // R2: a hit can only follow a change of the synchronised level
  p_hit_needs_change_r2: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (sync_q[SYNC_STAGES-1] != $past(sync_q[SYNC_STAGES-1])));
endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R10: a new event is never lost, even on the clearing edge
  p_set_kept_r10: assert property (@(posedge clk) disable iff (rst)
    |set_i |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int N     = 9,
  parameter int N_HI  = 4,
  parameter int VEC_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             hi_valid_o,
  output logic [VEC_W-1:0] hi_vec_o,
  output logic             lo_valid_o,
  output logic [VEC_W-1:0] lo_vec_o
);
  always_comb begin
    hi_valid_o = 1'b0;
    hi_vec_o   = '0;
    for (int i = N_HI - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hi_valid_o = 1'b1;
        hi_vec_o   = VEC_W'(i);
      end
    end
  end

  always_comb begin
    lo_valid_o = 1'b0;
    lo_vec_o   = '0;
    for (int i = N - 1; i >= N_HI; i--) begin
      if (req_i[i]) begin
        lo_valid_o = 1'b1;
        lo_vec_o   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int NUM_EV      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = $clog2(NUM_IN + NUM_EV)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IN-1:0]          pin_i,
  input  logic [2*NUM_IN-1:0]        edge_mode_i,
  input  logic [NUM_EV-1:0]          ev_strobe_i,
  input  logic [NUM_IN+NUM_EV-1:0]   enable_i,
  input  logic                       svc_done_i,
  output logic                       disp_valid_o,
  output logic [VEC_W-1:0]           disp_vec_o,
  output logic                       resume_o,
  output logic                       active_o,
  output logic [VEC_W-1:0]           cur_vec_o
);
  localparam int N_SRC = NUM_IN + NUM_EV;

  logic [NUM_IN-1:0] pin_hit;
  logic [N_SRC-1:0]  set_vec;
  logic [N_SRC-1:0]  clr_vec;
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  req;

  logic             hi_valid, lo_valid;
  logic [VEC_W-1:0] hi_vec, lo_vec;
  logic             do_hi, do_lo;

  logic             act_hi_q, act_lo_q;
  logic [VEC_W-1:0] hi_vec_q, lo_vec_q;
  logic             disp_valid_q, resume_q;
  logic [VEC_W-1:0] disp_vec_q;

  // contact input edge detectors
  for (genvar g = 0; g < NUM_IN; g++) begin : g_edge
    nic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[g]),
      .mode_i (edge_mode_i[2*g +: 2]),
      .hit_o  (pin_hit[g])
    );
  end

  assign set_vec = {ev_strobe_i, pin_hit};

  nic_pending #(.N(N_SRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  assign req = pend & enable_i;

  nic_arbiter #(.N(N_SRC), .N_HI(NUM_IN), .VEC_W(VEC_W)) u_arb (
    .req_i      (req),
    .hi_valid_o (hi_valid),
    .hi_vec_o   (hi_vec),
    .lo_valid_o (lo_valid),
    .lo_vec_o   (lo_vec)
  );

  // completion has precedence; dispatch is reconsidered the cycle after
  always_comb begin
    do_hi = hi_valid && !act_hi_q && !svc_done_i;
    do_lo = lo_valid && !hi_valid && !act_hi_q && !act_lo_q && !svc_done_i;
    for (int i = 0; i < N_SRC; i++) begin
      clr_vec[i] = (do_hi && (hi_vec == VEC_W'(i))) ||
                   (do_lo && (lo_vec == VEC_W'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi_q     <= 1'b0;
      act_lo_q     <= 1'b0;
      hi_vec_q     <= '0;
      lo_vec_q     <= '0;
      disp_valid_q <= 1'b0;
      disp_vec_q   <= '0;
      resume_q     <= 1'b0;
    end else begin
      disp_valid_q <= 1'b0;
      resume_q     <= 1'b0;
      if (svc_done_i) begin
        if (act_hi_q) begin
          act_hi_q <= 1'b0;
          resume_q <= act_lo_q;
        end else begin
          act_lo_q <= 1'b0;
        end
      end else if (do_hi) begin
        act_hi_q     <= 1'b1;
        hi_vec_q     <= hi_vec;
        disp_valid_q <= 1'b1;
        disp_vec_q   <= hi_vec;
      end else if (do_lo) begin
        act_lo_q     <= 1'b1;
        lo_vec_q     <= lo_vec;
        disp_valid_q <= 1'b1;
        disp_vec_q   <= lo_vec;
      end
    end
  end

  assign disp_valid_o = disp_valid_q;
  assign disp_vec_o   = disp_vec_q;
  assign resume_o     = resume_q;
  assign active_o     = act_hi_q | act_lo_q;
  assign cur_vec_o    = act_hi_q ? hi_vec_q : (act_lo_q ? lo_vec_q : '0);

  // R3: dispatched vectors are always valid source numbers
  p_vec_range_r3: assert property (@(posedge clk) disable iff (rst)
    disp_valid_q |-> (disp_vec_q < VEC_W'(N_SRC)));

  // R8: nothing is dispatched while an upper-level service runs
  p_no_same_level_r8: assert property (@(posedge clk) disable iff (rst)
    act_hi_q |=> !disp_valid_q);

  // R7: a running lower-level service can only be displaced by a contact input
  p_preempt_upper_only_r7: assert property (@(posedge clk) disable iff (rst)
    (act_lo_q && !act_hi_q) |=> (!disp_valid_q || (disp_vec_q < VEC_W'(NUM_IN))));

  // R9: a resume restores the stacked vector and dispatches nothing
  p_resume_vec_r9: assert property (@(posedge clk) disable iff (rst)
    resume_q |-> (!disp_valid_q && act_lo_q && !act_hi_q &&
                  cur_vec_o == $past(lo_vec_q)));

  // R12: completion while idle stays silent
  p_idle_done_r12: assert property (@(posedge clk) disable iff (rst)
    (!act_hi_q && !act_lo_q && svc_done_i) |=> (!disp_valid_q && !resume_q && !active_o));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 4;
  localparam int NEV = 5;
  localparam int NS  = NIN + NEV;

  logic            clk = 1'b0;
  logic            rst;
  logic [NIN-1:0]  pin;
  logic [2*NIN-1:0] mode;
  logic [NEV-1:0]  ev;
  logic [NS-1:0]   en;
  logic            done;
  logic            disp_valid, resume, active;
  logic [3:0]      disp_vec, cur_vec;

  int checks = 0;
  int fails  = 0;
  int disp_cnt = 0;
  int rd = 0;
  int res_cnt = 0;
  logic [3:0] disp_log [0:63];
  logic [3:0] res_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .edge_mode_i(mode), .ev_strobe_i(ev),
    .enable_i(en), .svc_done_i(done), .disp_valid_o(disp_valid),
    .disp_vec_o(disp_vec), .resume_o(resume), .active_o(active),
    .cur_vec_o(cur_vec)
  );

  // posedge logger sees the values registered on the previous edge
  always @(posedge clk) begin
    if (!rst && disp_valid) begin
      disp_log[disp_cnt[5:0]] <= disp_vec;
      disp_cnt <= disp_cnt + 1;
    end
    if (!rst && resume) begin
      res_cnt <= res_cnt + 1;
      res_vec <= cur_vec;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_disp(input int exp, input string tag);
    int w = 0;
    while (disp_cnt == rd && w < 20) begin
      @(negedge clk);
      w++;
    end
    if (disp_cnt > rd) begin
      check(disp_log[rd[5:0]] == 4'(exp), tag, disp_log[rd[5:0]], exp);
      rd++;
    end else begin
      check(1'b0, tag, -1, exp);
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    repeat (n) @(negedge clk);
    check(disp_cnt == rd, tag, disp_cnt - rd, 0);
    rd = disp_cnt;
  endtask

  task automatic svc_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic strobe(input logic [NEV-1:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic set_pins(input logic [NIN-1:0] p);
    @(negedge clk); pin = p;
  endtask

  task automatic t_reset();
    check(!disp_valid && !resume && !active && cur_vec == 0, "R1 reset state",
          {disp_valid, resume, active}, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); ev = 5'b00100;
    @(negedge clk); ev = '0;
    check(!disp_valid, "R3 no dispatch one cycle early", disp_valid, 0);
    @(negedge clk);
    check(disp_valid && disp_vec == 6, "R3 pulse-output 2 dispatch timing", disp_vec, 6);
    @(negedge clk);
    check(!disp_valid, "R3 strobe lasts one cycle", disp_valid, 0);
    expect_disp(6, "R3 logged vector");
    svc_done();
  endtask

  task automatic t_modes();
    @(negedge clk); mode = {2'b00, 2'b11, 2'b10, 2'b01};
    set_pins(4'b0001); expect_disp(0, "R2 rising mode, rise");  svc_done();
    set_pins(4'b0000); expect_none(8, "R2 rising mode ignores fall");
    set_pins(4'b0010); expect_none(8, "R2 falling mode ignores rise");
    set_pins(4'b0000); expect_disp(1, "R2 falling mode, fall"); svc_done();
    set_pins(4'b0100); expect_disp(2, "R2 both mode, rise");    svc_done();
    set_pins(4'b0000); expect_disp(2, "R2 both mode, fall");    svc_done();
    set_pins(4'b1000); expect_none(8, "R2 mode 00 rise");
    set_pins(4'b0000); expect_none(8, "R2 mode 00 fall");
    @(negedge clk); mode = {4{2'b01}};
  endtask

  task automatic t_in_order();
    set_pins(4'b1110);
    expect_disp(1, "R4 first input 1"); svc_done();
    expect_disp(2, "R4 then input 2");  svc_done();
    expect_disp(3, "R4 then input 3");  svc_done();
    set_pins(4'b0000); expect_none(6, "R4 no extra dispatch");
  endtask

  task automatic t_ev_order();
    strobe(5'b11111);
    expect_disp(4, "R5 timer first");     svc_done();
    expect_disp(5, "R5 pulse 1 second");  svc_done();
    expect_disp(6, "R5 pulse 2 third");   svc_done();
    expect_disp(7, "R5 counter 1 fourth"); svc_done();
    expect_disp(8, "R5 counter 2 last");  svc_done();
  endtask

  task automatic t_levels();
    @(negedge clk); en = '1; en[0] = 1'b0; en[8] = 1'b0;
    set_pins(4'b0001);
    strobe(5'b10000);
    expect_none(8, "R11 masked sources wait");
    @(negedge clk); en = '1;
    expect_disp(0, "R6 contact input beats event");
    expect_none(6, "R8 lower level waits for completion");
    svc_done();
    expect_disp(8, "R6 event after input");
    svc_done();
    set_pins(4'b0000);
  endtask

  task automatic t_nest();
    int r0;
    r0 = res_cnt;
    strobe(5'b00001);
    expect_disp(4, "R7 timer runs");
    set_pins(4'b0001);
    expect_disp(0, "R7 input 0 preempts timer");
    check(active && cur_vec == 0, "R7 running vector", cur_vec, 0);
    svc_done();
    @(negedge clk);
    check(res_cnt == r0 + 1, "R9 one resume pulse", res_cnt - r0, 1);
    check(res_vec == 4, "R9 resumed vector", res_vec, 4);
    check(active && cur_vec == 4, "R9 timer running again", cur_vec, 4);
    expect_none(3, "R9 resume dispatches nothing");
    svc_done();
    check(!active, "R9 idle after final return", active, 0);
    set_pins(4'b0000);
  endtask

  task automatic t_no_preempt();
    strobe(5'b00001);
    expect_disp(4, "R8 timer runs");
    strobe(5'b00010);
    expect_none(6, "R8 same level does not preempt");
    svc_done();
    expect_disp(5, "R8 waiting pulse 1 after return");
    set_pins(4'b0010);
    expect_disp(1, "R7 input 1 preempts pulse 1");
    set_pins(4'b0110);
    expect_none(6, "R8 input 2 waits behind input 1");
    svc_done();
    expect_disp(2, "R9 pending input preempts right after resume");
    svc_done();
    svc_done();
    check(!active, "R8 nest unwound", active, 0);
    set_pins(4'b0000);
    expect_none(6, "R8 nothing left over");
  endtask

  task automatic t_merge();
    @(negedge clk); en[7] = 1'b0;
    strobe(5'b01000); strobe(5'b01000); strobe(5'b01000);
    @(negedge clk); en[7] = 1'b1;
    expect_disp(7, "R10 merged counter 1 request");
    svc_done();
    expect_none(8, "R10 only one dispatch for repeats");
    @(negedge clk); ev = 5'b00001;
    @(negedge clk);
    @(negedge clk); ev = '0;
    expect_disp(4, "R10 timer first dispatch");
    svc_done();
    expect_disp(4, "R10 event on dispatch cycle kept");
    svc_done();
  endtask

  task automatic t_mask();
    @(negedge clk); en[5] = 1'b0;
    strobe(5'b00010);
    expect_none(8, "R11 disabled source not dispatched");
    @(negedge clk); en[5] = 1'b1;
    expect_disp(5, "R11 latched request after enable");
    svc_done();
  endtask

  task automatic t_idle_done();
    int r0;
    r0 = res_cnt;
    svc_done();
    expect_none(4, "R12 idle completion no dispatch");
    check(!active && res_cnt == r0, "R12 idle completion no resume", res_cnt - r0, 0);
  endtask

  initial begin
    rst = 1'b1; pin = '0; mode = {4{2'b01}}; ev = '0; en = '1; done = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_modes();
    t_in_order();
    t_ev_order();
    t_levels();
    t_nest();
    t_no_preempt();
    t_merge();
    t_mask();
    t_idle_done();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule